// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every word of a memory burst. A load pulse captures a starting column, an ordering select (sequential or interleaved) and a burst-length code. Each later step pulse from the memory controller moves the burst one word on. Only the low-order column bits that the burst length covers take part in the ordering. All higher column bits are carried through from the starting column.

The block keeps the address of the following word in a register one step ahead of the current one. On a step, the current column is therefore taken straight from that register, with no arithmetic in the path. The controller always has the next address ready before the processor asks for it, so wait states are needed only at the start of a burst. A last-word flag marks the final word of the burst. A step taken on the last word wraps the burst back to its first word.

Top module: `bcs_burst_seq`

## Requirements
- R1: While reset is held and after its release, before any load, col_o and next_col_o read 0 and last_o reads 1.
- R2: A load captures start_col_i and sets the word index to 0. In the next cycle col_o equals the captured start column.
- R3: With wrap_ilv_i = 0 (sequential), word i of a burst of length L has low bits equal to (start + i) mod L.
- R4: With wrap_ilv_i = 1 (interleaved), word i of a burst of length L has low bits equal to (start XOR i) mod L.
- R5: Column bits at or above log2(L) keep the values of the start column for the whole burst.
- R6: len_code_i selects the burst length: 0 gives 1 word, 1 gives 2 words, 2 gives 4 words and 3 gives 8 words.
- R7: last_o is high exactly when the word index equals L-1. A step taken while last_o is high returns the index to 0, so col_o goes back to the start column.
- R8: With a length of 1, col_o stays at the start column and last_o stays high under any number of steps and under either ordering.
- R9: next_col_o always shows the column that col_o takes after the next step. A step moves that value to col_o in the following cycle.
- R10: In a cycle with neither load nor step, col_o, next_col_o and last_o keep their values.
- R11: When load and step are both high in the same cycle, the load wins. The burst restarts at the new start column with index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture start column, ordering and length; index to 0 |
| step_i | input | 1 | Move to the following word of the burst |
| start_col_i | input | COL_W | Starting column address |
| wrap_ilv_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| len_code_i | input | 2 | Burst length code (1, 2, 4, 8 words) |
| col_o | output | COL_W | Column address of the current word |
| next_col_o | output | COL_W | Column address of the following word |
| last_o | output | 1 | Current word is the last of the burst |

## Verification
The bench builds the block with COL_W = 6. At that width every start column from 0 to 63 can be swept under both orderings and all four length codes. Each burst is stepped one word past its end, so the wrap to the start column is reached for every combination. Because the low three bits take all eight values at each upper value, every sequential carry that stops at the lane boundary is reached. The sweep also covers every interleaved XOR pattern. Further checks exercise idle cycles and loads that arrive together with a step.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  localparam int unsigned LANE_W   = 3;
  localparam int unsigned LCODE_W  = 2;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;

  typedef logic [LANE_W-1:0] lane_t;

  // Mask of the lane bits that a length code lets move.
  function automatic lane_t mask_of_code(input logic [LCODE_W-1:0] code);
    lane_t m;
    case (code)
      2'd0:    m = 3'b000;
      2'd1:    m = 3'b001;
      2'd2:    m = 3'b011;
      default: m = 3'b111;
    endcase
    return m;
  endfunction

  // Low bits for word idx of a burst, merged with the fixed start bits.
  function automatic lane_t lane_pick(input lane_t lo, input lane_t idx,
                                      input order_e ord, input lane_t mask);
    lane_t moved;
    if (ord == ORD_ILV) moved = lo ^ idx;
    else                moved = lo + idx;
    return (lo & ~mask) | (moved & mask);
  endfunction

  // Index advanced by n words, wrapped inside the burst.
  function automatic lane_t idx_adv(input lane_t idx, input lane_t n,
                                    input lane_t mask);
    lane_t s;
    s = idx + n;
    return s & mask;
  endfunction

endpackage

// File: rtl/bcs_cfg_reg.sv
module bcs_cfg_reg
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [COL_W-1:0]    start_in,
  input  order_e              ord_in,
  input  lane_t               mask_in,
  output logic [COL_W-1:0]    start_q,
  output order_e              ord_q,
  output lane_t               mask_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      ord_q   <= ORD_SEQ;
      mask_q  <= '0;
    end else if (load) begin
      start_q <= start_in;
      ord_q   <= ord_in;
      mask_q  <= mask_in;
    end
  end

endmodule

// File: rtl/bcs_index_ctr.sv
module bcs_index_ctr
  import bcs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  step,
  input  lane_t mask,
  output lane_t idx_q,
  output lane_t idx_plus2,
  output logic  at_last
);

  lane_t idx_plus1;

  always_comb begin
    idx_plus1 = idx_adv(idx_q, 3'd1, mask);
    idx_plus2 = idx_adv(idx_q, 3'd2, mask);
    at_last   = (idx_q == mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    idx_q <= '0;
    else if (load) idx_q <= '0;
    else if (step) idx_q <= idx_plus1;
  end

endmodule

// File: rtl/bcs_lane_gen.sv
module bcs_lane_gen
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] start,
  input  order_e           ord,
  input  lane_t            mask,
  input  lane_t            idx,
  output logic [COL_W-1:0] col
);

  localparam int unsigned UP_W = COL_W - LANE_W;

  lane_t lane;

  always_comb begin
    lane = lane_pick(start[LANE_W-1:0], idx, ord, mask);
    col  = {start[COL_W-1 -: UP_W], lane};
  end

endmodule

// File: rtl/bcs_burst_seq.sv
module bcs_burst_seq
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             wrap_ilv_i,
  input  logic [1:0]       len_code_i,
  output logic [COL_W-1:0] col_o,
  output logic [COL_W-1:0] next_col_o,
  output logic             last_o
);

  localparam int unsigned NGEN = 2;
  localparam int unsigned GEN_LOAD = 0;
  localparam int unsigned GEN_RUN  = 1;

  // Named internal events, visible to the bound checker.
  logic             load_ev;
  logic             step_ev;
  order_e           in_ord;
  lane_t            in_mask;
  logic [COL_W-1:0] cfg_start;
  order_e           cfg_ord;
  lane_t            cur_mask;
  lane_t            cur_idx;
  lane_t            idx_two;
  logic             idx_last;

  logic [COL_W-1:0] gen_start [NGEN];
  order_e           gen_ord   [NGEN];
  lane_t            gen_mask  [NGEN];
  lane_t            gen_idx   [NGEN];
  logic [COL_W-1:0] gen_col   [NGEN];

  logic [COL_W-1:0] col_q;
  logic [COL_W-1:0] next_q;

  assign load_ev = load_i;
  assign step_ev = step_i & ~load_i;
  assign in_ord  = wrap_ilv_i ? ORD_ILV : ORD_SEQ;
  assign in_mask = mask_of_code(len_code_i);

  bcs_cfg_reg #(.COL_W(COL_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_ev),
    .start_in (start_col_i),
    .ord_in   (in_ord),
    .mask_in  (in_mask),
    .start_q  (cfg_start),
    .ord_q    (cfg_ord),
    .mask_q   (cur_mask)
  );

  bcs_index_ctr u_idx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_ev),
    .step      (step_ev),
    .mask      (cur_mask),
    .idx_q     (cur_idx),
    .idx_plus2 (idx_two),
    .at_last   (idx_last)
  );

  // Generator 0 looks ahead for a fresh load (word 1 of the new burst);
  // generator 1 looks two words past the current one for a step.
  always_comb begin
    gen_start[GEN_LOAD] = start_col_i;
    gen_ord  [GEN_LOAD] = in_ord;
    gen_mask [GEN_LOAD] = in_mask;
    gen_idx  [GEN_LOAD] = idx_adv(3'd0, 3'd1, in_mask);
    gen_start[GEN_RUN]  = cfg_start;
    gen_ord  [GEN_RUN]  = cfg_ord;
    gen_mask [GEN_RUN]  = cur_mask;
    gen_idx  [GEN_RUN]  = idx_two;
  end

  for (genvar g = 0; g < NGEN; g++) begin : g_lane
    bcs_lane_gen #(.COL_W(COL_W)) u_gen (
      .start (gen_start[g]),
      .ord   (gen_ord[g]),
      .mask  (gen_mask[g]),
      .idx   (gen_idx[g]),
      .col   (gen_col[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q  <= '0;
      next_q <= '0;
    end else if (load_ev) begin
      col_q  <= start_col_i;
      next_q <= gen_col[GEN_LOAD];
    end else if (step_ev) begin
      col_q  <= next_q;
      next_q <= gen_col[GEN_RUN];
    end
  end

  assign col_o      = col_q;
  assign next_col_o = next_q;
  assign last_o     = idx_last;

endmodule

// File: rtl/bcs_burst_seq_chk.sv
module bcs_burst_seq_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic             step_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [COL_W-1:0] col_o,
  input logic [COL_W-1:0] next_col_o,
  input logic             last_o,
  input logic [2:0]       lane_mask,
  input logic [2:0]       idx
);

  logic [COL_W-1:0] up_mask;
  assign up_mask = ~{{(COL_W-3){1'b0}}, lane_mask};

  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (col_o == $past(start_col_i)) && (idx == 3'd0)) else $error("R2"); // R2

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ((col_o & up_mask) == ($past(col_o) & up_mask))) else $error("R5"); // R5

  AST_LAST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && last_o) |=> (idx == 3'd0)) else $error("R7"); // R7

  AST_LEN1_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mask == 3'd0) |-> (last_o && (col_o == next_col_o))) else $error("R8"); // R8

  AST_LOOKAHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (col_o == $past(next_col_o))) else $error("R9"); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> ($stable(col_o) && $stable(next_col_o) && $stable(last_o))) else $error("R10"); // R10

endmodule

bind bcs_burst_seq bcs_burst_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_i      (load_i),
  .step_i      (step_i),
  .start_col_i (start_col_i),
  .col_o       (col_o),
  .next_col_o  (next_col_o),
  .last_o      (last_o),
  .lane_mask   (cur_mask),
  .idx         (cur_idx)
);

// File: tb/tb_bcs_burst_seq.sv
module tb_bcs_burst_seq;

  localparam int W = 6;
  localparam time HALF = 4ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_i = 1'b0;
  logic         step_i = 1'b0;
  logic [W-1:0] start_col_i = '0;
  logic         wrap_ilv_i = 1'b0;
  logic [1:0]   len_code_i = '0;
  logic [W-1:0] col_o;
  logic [W-1:0] next_col_o;
  logic         last_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #HALF clk = ~clk;

  bcs_burst_seq #(.COL_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(step_i),
    .start_col_i(start_col_i), .wrap_ilv_i(wrap_ilv_i), .len_code_i(len_code_i),
    .col_o(col_o), .next_col_o(next_col_o), .last_o(last_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected column of word i, written with modulo arithmetic.
  function automatic int exp_col(input int s, input bit ilv, input int len, input int i);
    int base, low, w;
    low  = s % len;
    base = s - low;
    w    = i % len;
    if (ilv) return base + ((low ^ w) % len);
    else     return base + ((low + w) % len);
  endfunction

  function automatic int len_of(input int code);
    return 1 << code;
  endfunction

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic check_word(input int s, input bit ilv, input int len, input int i);
    chk(ilv ? "R4 col" : "R3 col", int'(col_o), exp_col(s, ilv, len, i));
    chk("R9 next", int'(next_col_o), exp_col(s, ilv, len, i + 1));
    chk("R7/R6 last", int'(last_o), ((i % len) == len - 1) ? 1 : 0);
    chk("R5 upper", int'(col_o) / len, s / len);
  endtask

  initial begin
    #(2 * HALF * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk("R1 col", int'(col_o), 0);
    chk("R1 next", int'(next_col_o), 0);
    chk("R1 last", int'(last_o), 1);
    rst_n = 1'b1;
    tick();
    chk("R1 col after release", int'(col_o), 0);
    chk("R1 last after release", int'(last_o), 1);

    for (int code = 0; code < 4; code++) begin
      for (int m = 0; m < 2; m++) begin
        for (int s = 0; s < (1 << W); s++) begin
          int len;
          len = len_of(code);
          load_i = 1'b1; step_i = 1'b0;
          start_col_i = W'(s); wrap_ilv_i = m[0]; len_code_i = 2'(code);
          tick();
          load_i = 1'b0;
          chk("R2 load start", int'(col_o), s);
          check_word(s, m[0], len, 0);
          for (int i = 1; i <= len; i++) begin
            step_i = 1'b1;
            tick();
            step_i = 1'b0;
            check_word(s, m[0], len, i);
            if (code == 0) chk("R8 len1", int'(col_o), s);
          end
          if ((s % 16) == 5) begin
            tick();
            check_word(s, m[0], len, len);
            chk("R10 idle hold", int'(col_o), exp_col(s, m[0], len, 0));
          end
        end
      end
    end

    // Load together with step: load wins.
    for (int k = 0; k < 4; k++) begin
      int s2;
      s2 = 13 + 11 * k;
      load_i = 1'b1; step_i = 1'b0; start_col_i = 6'd6; wrap_ilv_i = 1'b0; len_code_i = 2'd3;
      tick();
      load_i = 1'b0; step_i = 1'b1;
      tick();
      tick();
      load_i = 1'b1; step_i = 1'b1; start_col_i = W'(s2); wrap_ilv_i = k[0]; len_code_i = 2'd2;
      tick();
      load_i = 1'b0; step_i = 1'b0;
      chk("R11 load wins col", int'(col_o), s2);
      chk("R11 load wins next", int'(next_col_o), exp_col(s2, k[0], 4, 1));
      chk("R11 load wins last", int'(last_o), 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule